// File: doc/BRIEF.md
# Logical-Channel Conversion Sequencer with Result Buffer

This block walks an ordered list of logical channel entries and asks an external converter for one conversion per entry. Each entry is a setup word that names a physical input and carries that input's setup bits. The same physical input may appear more than once, in any order. The converter works through a request/acknowledge pair and may take any number of cycles to answer. The block tags each answer with its logical slot and physical input, and appends it to a small result buffer.

A start pulse launches a run, and the configuration is captured at that moment. In multi-entry mode the run covers entries 0 through the configured last index. In single-entry mode it covers only the entry named with the start pulse. When the run ends, a done flag rises and the host pops the results one per cycle. With repeat mode on, a drained buffer starts the next pass from entry 0. An abort input stops everything and discards the results.

Top module: `chan_seq_fifo`

## Requirements
- R1: Entry k occupies `setup_regs[(7-k)*12 +: 12]`, so the lower-numbered entry of each 24-bit pair sits in the upper half. While a request is pending, `conv_setup` shows the whole current entry and `conv_phys` shows its top two bits [11:10].
- R2: In multi-entry mode, a `cfg_depth` value of d converts entries 0..d in ascending order, one request per entry, with repeated physical inputs allowed. The value 5 gives six results.
- R3: Each acknowledged conversion is appended to the buffer in order as a 24-bit word: {data[15:0], logical index[2:0], physical input[1:0], 3'b000}. `res_count` equals the number of stored, unread words and never exceeds 8.
- R4: `seq_done` rises on the cycle after the last entry's acknowledge and never coexists with `conv_req`. Each cycle with `rd_en` pops one word, and `rd_data` always shows the oldest unread word. The flag falls when the buffer is empty.
- R5: `conv_first` is high during the first request after a start pulse and low for every later request, including later passes in repeat mode.
- R6: In single-entry mode, exactly one conversion is made, for entry `start_entry`, and the run completes with one result.
- R7: In repeat mode, which needs multi-entry mode as well, draining the last word starts the next pass from entry 0 on the following cycle. Results are never overwritten while unread.
- R8: A start pulse while `seq_busy` is high has no effect. Changes to `cfg_*` after the start pulse do not alter the running sequence.
- R9: `abort` returns the block to idle on the next cycle, with `res_count` at 0 and no request pending.
- R10: `rd_en` outside the done phase pops nothing.
- R11: After reset the block is idle: no request, no done, empty buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| setup_regs | input | 96 | Eight packed 12-bit entries, entry 0 in the top bits |
| cfg_depth | input | 3 | Last entry index for multi-entry mode |
| cfg_multi | input | 1 | 1: convert the list; 0: single entry |
| cfg_loop | input | 1 | Repeat passes (multi-entry mode only) |
| start | input | 1 | Launch a run when idle |
| start_entry | input | 3 | Entry used in single-entry mode |
| abort | input | 1 | Stop and discard results |
| conv_req | output | 1 | Conversion request pending |
| conv_phys | output | 2 | Physical input of the pending request |
| conv_setup | output | 12 | Full entry of the pending request |
| conv_first | output | 1 | Pending request is the first of the run |
| conv_ack | input | 1 | Converter finished the pending request |
| conv_data | input | 16 | Conversion result, valid with conv_ack |
| seq_busy | output | 1 | A run is active or results are waiting |
| seq_done | output | 1 | Run complete, results readable |
| rd_en | input | 1 | Pop one result |
| rd_data | output | 24 | Oldest unread result word |
| res_count | output | 4 | Number of unread results |

## Verification
A wrong slot index or last-index capture shows on the very next request as the wrong `conv_setup`, or as a done flag that comes one acknowledge early or late. Broken buffer pointers show up in `res_count` on the cycle after the faulty push or pop, and in `rd_data` whenever done is high. A stale first flag or a bad repeat decision is visible on the first request after the drain. The bench holds its own model of the sequence and compares all outputs on every cycle, so each such fault surfaces within one clock of the cycle it occurs.

// File: rtl/chan_seq_fifo.sv
module chan_seq_fifo #(
  parameter int N_ENTRY = 8,
  parameter int ENTRY_W = 12,
  parameter int PHYS_W  = 2,
  parameter int DATA_W  = 16,
  parameter int RES_W   = 24,
  localparam int IDX_W  = $clog2(N_ENTRY)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_ENTRY*ENTRY_W-1:0] setup_regs,
  input  logic [IDX_W-1:0]           cfg_depth,
  input  logic                       cfg_multi,
  input  logic                       cfg_loop,
  input  logic                       start,
  input  logic [IDX_W-1:0]           start_entry,
  input  logic                       abort,
  output logic                       conv_req,
  output logic [PHYS_W-1:0]          conv_phys,
  output logic [ENTRY_W-1:0]         conv_setup,
  output logic                       conv_first,
  input  logic                       conv_ack,
  input  logic [DATA_W-1:0]          conv_data,
  output logic                       seq_busy,
  output logic                       seq_done,
  input  logic                       rd_en,
  output logic [RES_W-1:0]           rd_data,
  output logic [IDX_W:0]             res_count
);
  localparam int PAD_W = RES_W - DATA_W - IDX_W - PHYS_W;

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_HOLD} st_t;
  st_t st;

  logic [ENTRY_W-1:0] ent [N_ENTRY];
  logic [RES_W-1:0]   mem [N_ENTRY];
  logic [IDX_W-1:0]   idx, last;
  logic               loop_q, first_q;
  logic [IDX_W:0]     wr_cnt, rd_cnt;

  for (genvar g = 0; g < N_ENTRY; g++) begin : g_unpack
    assign ent[g] = setup_regs[(N_ENTRY-1-g)*ENTRY_W +: ENTRY_W];
  end

  wire push = (st == S_CONV) && conv_ack && !abort;
  wire pop  = (st == S_HOLD) && rd_en && !abort;

  assign conv_req   = (st == S_CONV);
  assign conv_setup = ent[idx];
  assign conv_phys  = conv_setup[ENTRY_W-1 -: PHYS_W];
  assign conv_first = first_q && conv_req;
  assign seq_busy   = (st != S_IDLE);
  assign seq_done   = (st == S_HOLD);
  assign res_count  = wr_cnt - rd_cnt;
  assign rd_data    = mem[rd_cnt[IDX_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      idx     <= '0;
      last    <= '0;
      loop_q  <= 1'b0;
      first_q <= 1'b0;
      wr_cnt  <= '0;
      rd_cnt  <= '0;
    end else if (abort) begin
      st      <= S_IDLE;
      first_q <= 1'b0;
      wr_cnt  <= '0;
      rd_cnt  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st      <= S_CONV;
          idx     <= cfg_multi ? '0 : start_entry;
          last    <= cfg_multi ? cfg_depth : start_entry;
          loop_q  <= cfg_loop && cfg_multi;
          first_q <= 1'b1;
          wr_cnt  <= '0;
          rd_cnt  <= '0;
        end
        S_CONV: if (conv_ack) begin
          wr_cnt  <= wr_cnt + 1'b1;
          first_q <= 1'b0;
          if (idx == last) st <= S_HOLD;
          else idx <= idx + 1'b1;
        end
        S_HOLD: if (rd_en) begin
          rd_cnt <= rd_cnt + 1'b1;
          if (rd_cnt + 1'b1 == wr_cnt) begin
            if (loop_q) begin
              st     <= S_CONV;
              idx    <= '0;
              wr_cnt <= '0;
              rd_cnt <= '0;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_cnt[IDX_W-1:0]] <= {conv_data, idx, conv_phys, {PAD_W{1'b0}}};
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (wr_cnt < (IDX_W+1)'(N_ENTRY)));
  assert_done_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && idx == last) |=> seq_done);
  assert_done_excl_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_done && conv_req));
  assert_pop_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> ((rd_cnt == $past(rd_cnt) + 1'b1) || (wr_cnt == '0 && rd_cnt == '0)));
  assert_first_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_first |-> (res_count == '0));
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && start && !conv_ack && !abort) |=> ($stable(idx) && $stable(last)));
  assert_abort_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!seq_busy && res_count == '0));
  assert_rd_outside_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !seq_done && !abort) |=> (rd_cnt == $past(rd_cnt) || rd_cnt == '0));
endmodule

// File: tb/tb_chan_seq_fifo.sv
`timescale 1ns/1ps
module tb_chan_seq_fifo;
  localparam int N = 8, EW = 12, PW = 2, DW = 16, RW = 24, IW = 3;
  localparam int LAT = 4, FIRST_X = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N*EW-1:0] setup_regs;
  logic [IW-1:0] cfg_depth = '0, start_entry = '0;
  logic cfg_multi = 1'b0, cfg_loop = 1'b0, start = 1'b0, abort = 1'b0;
  logic conv_ack = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] conv_data = '0;
  logic conv_req, conv_first, seq_busy, seq_done;
  logic [PW-1:0] conv_phys;
  logic [EW-1:0] conv_setup;
  logic [RW-1:0] rd_data;
  logic [IW:0] res_count;

  chan_seq_fifo dut (
    .clk(clk), .rst_n(rst_n), .setup_regs(setup_regs), .cfg_depth(cfg_depth),
    .cfg_multi(cfg_multi), .cfg_loop(cfg_loop), .start(start), .start_entry(start_entry),
    .abort(abort), .conv_req(conv_req), .conv_phys(conv_phys), .conv_setup(conv_setup),
    .conv_first(conv_first), .conv_ack(conv_ack), .conv_data(conv_data),
    .seq_busy(seq_busy), .seq_done(seq_done), .rd_en(rd_en), .rd_data(rd_data),
    .res_count(res_count));

  logic [EW-1:0] ent [N];
  int n_cmp = 0, n_bad = 0, cnt = 0, serial = 0;
  bit live = 0, ended = 0;
  int m_state = 0, m_idx = 0, m_last = 0;
  bit m_loop = 0, m_first = 0;
  logic [RW-1:0] m_q [$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_first = 0; m_q.delete();
    end else if (abort) begin
      m_state = 0; m_q.delete();
    end else begin
      case (m_state)
        0: if (start) begin
          m_idx   = cfg_multi ? 0 : int'(start_entry);
          m_last  = cfg_multi ? int'(cfg_depth) : int'(start_entry);
          m_loop  = cfg_loop && cfg_multi;
          m_first = 1;
          m_q.delete();
          m_state = 1;
        end
        1: if (conv_ack) begin
          m_q.push_back({conv_data, 3'(m_idx), ent[m_idx][EW-1 -: PW], 3'b000});
          m_first = 0;
          if (m_idx == m_last) m_state = 2;
          else m_idx++;
        end
        2: if (rd_en) begin
          void'(m_q.pop_front());
          if (m_q.size() == 0) begin
            if (m_loop) begin m_idx = 0; m_state = 1; end
            else m_state = 0;
          end
        end
        default: m_state = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (live) begin
      check("R8 busy", 32'(seq_busy), 32'(m_state != 0));
      check("R2 request", 32'(conv_req), 32'(m_state == 1));
      if (m_state == 1) begin
        check("R1 setup", 32'(conv_setup), 32'(ent[m_idx]));
        check("R1 phys", 32'(conv_phys), 32'(ent[m_idx][EW-1 -: PW]));
        check("R5 first", 32'(conv_first), 32'(m_first));
      end
      check("R4 done", 32'(seq_done), 32'(m_state == 2));
      check("R3 count", 32'(res_count), 32'(m_q.size()));
      if (m_state == 2 && m_q.size() > 0) check("R3 data", 32'(rd_data), 32'(m_q[0]));
    end
    if (rst_n && m_state == 1) begin
      cnt++;
      if (cnt >= LAT + (m_first ? FIRST_X : 0)) begin
        conv_ack = 1'b1;
        conv_data = 16'(serial * 37 + 4096);
        serial++;
        cnt = 0;
      end else conv_ack = 1'b0;
    end else begin
      conv_ack = 1'b0;
      cnt = 0;
    end
  end

  task automatic go(bit m, bit l, int d, int e);
    @(negedge clk);
    cfg_multi = m; cfg_loop = l; cfg_depth = 3'(d); start_entry = 3'(e); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int g = 0;
    while (!seq_done && g < 2000) begin @(negedge clk); g++; end
    check("R4 done reached", 32'(seq_done), 32'd1);
  endtask

  task automatic drain(int n);
    rd_en = 1'b1;
    repeat (n) @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    int order [N] = '{3, 0, 3, 1, 3, 2, 3, 0};
    for (int k = 0; k < N; k++) begin
      ent[k] = {2'(order[k]), 10'(k * 41 + 5)};
      setup_regs[(N-1-k)*EW +: EW] = ent[k];
    end
    repeat (3) @(negedge clk);
    check("R11 reset busy", 32'(seq_busy), 0);
    check("R11 reset req", 32'(conv_req), 0);
    check("R11 reset done", 32'(seq_done), 0);
    check("R11 reset count", 32'(res_count), 0);
    rst_n = 1'b1;
    live = 1;

    go(1, 0, 5, 0);
    cfg_depth = 3'd7;
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done();
    check("R2 six results", 32'(res_count), 32'd6);
    drain(6);
    check("R4 idle after drain", 32'(seq_busy), 0);

    go(0, 0, 0, 6);
    wait_done();
    check("R6 single result", 32'(res_count), 32'd1);
    check("R6 entry index", 32'(rd_data[7:5]), 32'd6);
    go(1, 0, 7, 0);
    check("R8 start in done ignored", 32'(res_count), 32'd1);
    drain(1);

    go(1, 0, 7, 0);
    wait_done();
    check("R3 full buffer", 32'(res_count), 32'd8);
    drain(8);

    go(1, 0, 2, 0);
    while (res_count == 0) @(negedge clk);
    rd_en = 1'b1; repeat (2) @(negedge clk); rd_en = 1'b0;
    check("R10 nothing popped", 32'(res_count != 0), 32'd1);
    wait_done();
    check("R10 all kept", 32'(res_count), 32'd3);
    drain(3);

    go(1, 1, 1, 0);
    wait_done();
    check("R7 pass one", 32'(res_count), 32'd2);
    drain(2);
    check("R7 restarted", 32'(conv_req), 32'd1);
    check("R7 not first", 32'(conv_first), 32'd0);
    wait_done();
    check("R7 pass two", 32'(res_count), 32'd2);
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    check("R9 idle", 32'(seq_busy), 0);
    check("R9 emptied", 32'(res_count), 0);

    go(1, 0, 3, 0);
    repeat (15) @(negedge clk);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    check("R9 mid-run idle", 32'(seq_busy), 0);
    check("R9 mid-run req", 32'(conv_req), 0);
    go(1, 0, 0, 2);
    wait_done();
    check("R2 depth zero", 32'(res_count), 32'd1);
    check("R2 depth zero index", 32'(rd_data[7:5]), 32'd0);
    drain(1);
    repeat (5) @(negedge clk);
    finish_up();
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_up();
  end
endmodule